// File: doc/BRIEF.md
# Software Store Unlock Detector

This block sits beside a byte-wide memory with a 13-bit address and watches every access the host makes to it. Each access shows up as a single-cycle strobe, with the address and a write flag beside it. When the host reads six fixed addresses in a fixed order and makes no other access in between, the block starts a store. A store copies the memory into its nonvolatile shadow, so the block first signals an erase phase and then a program phase.

Both phase lengths are parameters counted in clock cycles. A busy flag stays high over both phases. While it is high, the surrounding memory interface is meant to be disabled, and this block ignores every strobe.

A read of the wrong address breaks a partly entered sequence, and so does a write to any address. If the breaking access is itself a read of the first unlock address, it opens a new sequence at step 1. Because a write never advances the sequence, a host that unlocks the store must use plain reads only. Whether output enable was active during those reads does not matter to this block.

Top module: `nv_store_seq`

## Requirements
- R1: The unlock addresses, in order, are 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0F. Each one must be a read, that is, a strobe with `acc_wr`=0. When the sixth read is strobed at a rising edge, `store_busy` and `erase_phase` are both 1 right after that edge.
- R2: After a store starts, `erase_phase` stays 1 for exactly ERASE_CYC cycles. Then `program_phase` stays 1 for exactly PROG_CYC cycles. After that, all three outputs return to 0.
- R3: A read of an address that is not the expected next unlock address aborts the sequence. Finishing the remaining addresses afterwards starts no store.
- R4: A strobe with `acc_wr`=1 aborts the sequence, whatever its address is, including the expected next address.
- R5: A read of 0x0000 always leaves the sequence at step 1, whatever step it was at before, so that reading the other five addresses next starts a store.
- R6: While `store_busy` is 1, strobes are ignored. A full sequence presented during a store starts no second store, and it leaves no progress behind.
- R7: After synchronous reset, all outputs are 0 and the sequence is at step 0. Reading only the last five unlock addresses then starts no store.
- R8: `erase_phase` and `program_phase` are never 1 together. `store_busy` equals their OR.
- R9: Changes on the address or write inputs without a strobe have no effect on the sequence or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb | input | 1 | One-cycle pulse marking one access (chip enable falling) |
| acc_addr | input | ADDR_W | Address of the access |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| store_busy | output | 1 | Store in progress; memory interface disabled |
| erase_phase | output | 1 | Store is erasing the nonvolatile copy |
| program_phase | output | 1 | Store is programming the nonvolatile copy |

## Verification
The assertions check on every cycle that:
- the two phase flags are exclusive and their OR matches the busy flag;
- the program phase starts only as the erase phase ends;
- a write clears the step and a read of 0x0000 sets it to 1;
- the step holds still during a store;
- a completed sequence raises busy and erase on the next cycle.

Other behaviour only the bench scenarios can show. That covers the exact phase lengths, and that out-of-order, write-broken or partial sequences start no store. It also covers that a sequence entered during a store leaves nothing behind, and that a restart at 0x0000 still leads to a store.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  localparam int UNLOCK_ADDR_W = 13;
  localparam int UNLOCK_STEPS  = 6;
  localparam int STEP_W        = $clog2(UNLOCK_STEPS);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_PROG  = 2'd2
  } store_phase_t;

  // Expected address for each step of the unlock sequence (order is behaviour).
  function automatic logic [UNLOCK_ADDR_W-1:0] unlock_addr(input int idx);
    logic [UNLOCK_ADDR_W-1:0] a;
    case (idx)
      0:       a = 13'h0000;
      1:       a = 13'h1555;
      2:       a = 13'h0AAA;
      3:       a = 13'h1FFF;
      4:       a = 13'h10F0;
      5:       a = 13'h0F0F;
      default: a = 13'h0000;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/unlock_tracker.sv
module unlock_tracker #(
  parameter int ADDR_W = nvs_pkg::UNLOCK_ADDR_W,
  parameter int NSTEP  = nvs_pkg::UNLOCK_STEPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_stb,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic              hold,
  output logic              seq_done
);
  localparam int SW = $clog2(NSTEP);

  logic [NSTEP-1:0] hit;
  logic [SW-1:0]    step_q, step_d;
  logic             expect_hit;

  // One comparator per sequence position.
  for (genvar i = 0; i < NSTEP; i++) begin : g_cmp
    assign hit[i] = (acc_addr == ADDR_W'(nvs_pkg::unlock_addr(i)));
  end

  always_comb begin
    expect_hit = 1'b0;
    for (int k = 0; k < NSTEP; k++) begin
      if (step_q == SW'(k)) expect_hit = hit[k];
    end
  end

  always_comb begin
    step_d   = step_q;
    seq_done = 1'b0;
    if (acc_stb && !hold) begin
      if (acc_wr) begin
        step_d = '0;
      end else if (expect_hit) begin
        if (step_q == SW'(NSTEP-1)) begin
          seq_done = 1'b1;
          step_d   = '0;
        end else begin
          step_d = step_q + SW'(1);
        end
      end else if (hit[0]) begin
        step_d = SW'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end

  // R4: a write strobe outside a store leaves the step at 0
  a_r4_write_clears: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && acc_wr && !hold) |=> (step_q == '0));

  // R5: any read of the first unlock address parks the step at 1
  a_r5_zero_read_restarts: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && !acc_wr && !hold && acc_addr == '0) |=> (step_q == SW'(1)));

  // R6: the step is frozen during a store
  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(step_q));

  // R9: no strobe, no step movement
  a_r9_no_stb_no_move: assert property (@(posedge clk) disable iff (rst)
    !acc_stb |=> $stable(step_q));

endmodule

// File: rtl/store_timer.sv
module store_timer #(
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic erase,
  output logic prog
);
  import nvs_pkg::*;

  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  store_phase_t     ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, erase_q, prog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      prog_q  <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start) begin
            ph_q    <= PH_ERASE;
            cnt_q   <= CNT_W'(ERASE_CYC - 1);
            busy_q  <= 1'b1;
            erase_q <= 1'b1;
          end
        end
        PH_ERASE: begin
          if (cnt_q == '0) begin
            ph_q    <= PH_PROG;
            cnt_q   <= CNT_W'(PROG_CYC - 1);
            erase_q <= 1'b0;
            prog_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_PROG: begin
          if (cnt_q == '0) begin
            ph_q   <= PH_IDLE;
            prog_q <= 1'b0;
            busy_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy  = busy_q;
  assign erase = erase_q;
  assign prog  = prog_q;

  // R8: phases exclusive
  a_r8_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(erase_q && prog_q));

  // R8: busy is exactly the union of the phases
  a_r8_busy_union: assert property (@(posedge clk) disable iff (rst)
    busy_q == (erase_q || prog_q));

  // R2: erase hands over straight to program
  a_r2_erase_to_prog: assert property (@(posedge clk) disable iff (rst)
    $fell(erase_q) |-> prog_q);

  // R2: program is only entered from erase
  a_r2_prog_after_erase: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_q) |-> $past(erase_q));

  initial begin
    a_r2_params_positive: assert (ERASE_CYC >= 1 && PROG_CYC >= 1);
  end

endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq #(
  parameter int ADDR_W    = nvs_pkg::UNLOCK_ADDR_W,
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_stb,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  output logic              store_busy,
  output logic              erase_phase,
  output logic              program_phase
);
  logic seq_done;
  logic busy_w;

  unlock_tracker #(
    .ADDR_W (ADDR_W),
    .NSTEP  (nvs_pkg::UNLOCK_STEPS)
  ) u_track (
    .clk      (clk),
    .rst      (rst),
    .acc_stb  (acc_stb),
    .acc_addr (acc_addr),
    .acc_wr   (acc_wr),
    .hold     (busy_w),
    .seq_done (seq_done)
  );

  store_timer #(
    .ERASE_CYC (ERASE_CYC),
    .PROG_CYC  (PROG_CYC)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (seq_done),
    .busy  (busy_w),
    .erase (erase_phase),
    .prog  (program_phase)
  );

  assign store_busy = busy_w;

  // R1: completion is visible as busy+erase on the next cycle
  a_r1_start_visible: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> (store_busy && erase_phase));

  // R6: no completion is reported during a store
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    store_busy |-> !seq_done);

endmodule

// File: tb/nv_store_seq_test.sv
module nv_store_seq_test;
  localparam int CLK_NS = 10;
  localparam int E_CYC  = 5;
  localparam int P_CYC  = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stb = 1'b0;
  logic        wr  = 1'b0;
  logic [12:0] addr = '0;
  logic        busy, er, pr;

  nv_store_seq #(.ADDR_W(13), .ERASE_CYC(E_CYC), .PROG_CYC(P_CYC)) uut (
    .clk(clk), .rst(rst), .acc_stb(stb), .acc_addr(addr), .acc_wr(wr),
    .store_busy(busy), .erase_phase(er), .program_phase(pr)
  );

  always #(CLK_NS/2) clk = ~clk;

  logic [2:0] exp_q[$];
  string      tag_q[$];
  int n_run = 0, n_fail = 0;
  int m_step = 0, m_left = 0;
  bit done = 1'b0;

  function automatic logic [12:0] key(input int i);
    logic [12:0] k;
    case (i)
      0: k = 13'h0000; 1: k = 13'h1555; 2: k = 13'h0AAA;
      3: k = 13'h1FFF; 4: k = 13'h10F0; default: k = 13'h0F0F;
    endcase
    return k;
  endfunction

  // Driver: one cycle of stimulus plus the expected outputs after the next edge.
  task automatic cyc(input bit s, input logic [12:0] a, input bit w, input string tag);
    @(negedge clk);
    stb = s; addr = a; wr = w;
    if (m_left > 0) m_left--;
    else if (s) begin
      if (w) m_step = 0;
      else if (a == key(m_step)) begin
        if (m_step == 5) begin m_step = 0; m_left = E_CYC + P_CYC; end
        else m_step++;
      end else if (a == 13'h0000) m_step = 1;
      else m_step = 0;
    end
    exp_q.push_back({m_left > 0, m_left > P_CYC, (m_left > 0 && m_left <= P_CYC)});
    tag_q.push_back(tag);
  endtask

  task automatic access(input logic [12:0] a, input bit w, input string tag);
    cyc(1'b1, a, w, tag);
    cyc(1'b0, 13'h1ABC, 1'b0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 13'(i * 37), i[0], tag);
  endtask

  task automatic full_seq(input string tag);
    for (int i = 0; i < 6; i++) access(key(i), 1'b0, tag);
  endtask

  // Monitor: pop and compare after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if ({busy, er, pr} !== e) begin
        n_fail++;
        $display("FAIL %s: busy/erase/prog got %b expected %b", t, {busy, er, pr}, e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;
    if ({busy, er, pr} !== 3'b000) begin
      n_fail++;
      $display("FAIL R7 reset: got %b expected 000", {busy, er, pr});
    end
    rst = 1'b0;

    // R7: only the last five addresses after reset do nothing
    for (int i = 1; i < 6; i++) access(key(i), 1'b0, "R7 step0 after reset");
    idle(4, "R7 idle");

    // R9: address/write wiggle without strobe
    idle(20, "R9 no strobe");

    // R1 / R2 / R8: clean sequence and full store timing
    full_seq("R1 clean sequence");
    idle(E_CYC + P_CYC + 4, "R2 phase timing");

    // R3: wrong read in the middle
    access(key(0), 1'b0, "R3 abort"); access(key(1), 1'b0, "R3 abort");
    access(key(2), 1'b0, "R3 abort"); access(13'h1234, 1'b0, "R3 abort");
    access(key(3), 1'b0, "R3 abort"); access(key(4), 1'b0, "R3 abort");
    access(key(5), 1'b0, "R3 abort");
    idle(4, "R3 no store");

    // R4: write to the expected address breaks the sequence
    access(key(0), 1'b0, "R4 write"); access(key(1), 1'b0, "R4 write");
    access(key(2), 1'b1, "R4 write"); access(key(2), 1'b0, "R4 write");
    access(key(3), 1'b0, "R4 write"); access(key(4), 1'b0, "R4 write");
    access(key(5), 1'b0, "R4 write");
    idle(4, "R4 no store");

    // R5: aborting read of 0x0000 restarts at step 1
    access(key(0), 1'b0, "R5 restart"); access(key(1), 1'b0, "R5 restart");
    access(key(2), 1'b0, "R5 restart"); access(key(0), 1'b0, "R5 restart");
    access(key(0), 1'b0, "R5 restart");
    for (int i = 1; i < 6; i++) access(key(i), 1'b0, "R5 restart");
    idle(E_CYC + P_CYC + 4, "R5 store runs");

    // R6: sequence during busy is ignored and leaves nothing behind
    full_seq("R6 start");
    cyc(1'b1, key(0), 1'b0, "R6 busy ignore");
    for (int i = 1; i < 6; i++) cyc(1'b1, key(i), 1'b0, "R6 busy ignore");
    idle(E_CYC + P_CYC, "R6 drain");
    for (int i = 1; i < 6; i++) access(key(i), 1'b0, "R6 no carry-over");
    idle(4, "R6 no store");
    full_seq("R6 fresh sequence");
    idle(E_CYC + P_CYC + 3, "R6 second store");

    @(posedge clk); #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule